// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block sequences the electronic shutter of an interline CCD. It follows the line and field strobes from the sync generator and counts pixel clocks inside each line. From these counts it produces the substrate-discharge pulse train (one pulse per selected line), a one-cycle readout strobe that marks the midpoint of the readout pulses, and an exposure flag that is high while charge is being integrated.

Three shutter parameters set the shape of the exposure. The vertical count is the number of extra fields that one exposure spans. The horizontal count sets the number of discharge lines in the burst field. The partial-field index selects which field of a multi-field span carries the burst. The parameters and the shutter enable are sampled only at the field boundary that closes a span. A busy output tells the controller that a long exposure is in progress, so that it can hold off new parameters. A readout-gate override suppresses the readout, which lets the exposure run on across field boundaries.

A field starts when the field strobe and the line strobe are high in the same cycle. Line 0 of a field is the readout line. Clock `c` of a line is the value the clock counter holds `c` cycles after the edge that sampled the line strobe. A registered output that depends on clock `c` changes at the following edge.

Top module: `ccd_shutter_seq`

## Requirements
- R1: A synchronous active-low reset clears the clock, line, field and parameter state. While reset is held, and afterwards until a field strobe arrives, `sub_o`, `exp_o`, `readout_o` and `busy_o` stay low, and line strobes alone produce no pulse.
- R2: A discharge pulse is high for the clocks from `SUB_ON` to `SUB_OFF`-1 of a burst line. It is therefore visible from `SUB_ON`+1 to `SUB_OFF` cycles after the line-strobe edge, and it lasts exactly `SUB_OFF`-`SUB_ON` cycles.
- R3: With the shutter enabled, the burst field has `h`+1 pulses, one on each of lines 1 to `h`+1, where `h` is bits [10:0] of `hcount_i`. Bit 11 is reserved and has no effect.
- R4: With the shutter disabled at the span-closing field strobe, the vertical count, horizontal count and partial-field index are ignored. No pulse is issued, every field is a one-field span, and `exp_o` rises at clock `NOSUB_RISE` of the readout line.
- R5: A vertical count `v` of 0 gives a one-field span, so a readout happens in every field. A count of 1 or more gives a span of `v`+1 fields, and there is exactly one readout, in line 0 of the span's first field.
- R6: The burst occurs in field `min(p, v)` of the span, where the fields are numbered 0, 1, 2 and so on from the field strobe that loaded the parameters.
- R7: With the shutter enabled, `exp_o` rises on the same edge on which the last discharge pulse falls.
- R8: `readout_o` is high for one cycle at clock `MID_FRAME` when `frame_mode_i` is 1, or at clock `MID_DRAFT` when it is 0, of the readout line, and `exp_o` falls on that same edge. `exp_o` falls at no other time.
- R9: While `sg_hold_i` is high, the readout is suppressed: `readout_o` stays low and `exp_o` is neither cleared nor set by the readout line.
- R10: `busy_o` is high during a span whose vertical count is 1 or more, and it changes only on a field-strobe edge. Changes to the parameter inputs in the middle of a span have no effect on that span.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| hd_i | input | 1 | Line strobe, one cycle per line |
| vd_i | input | 1 | Field strobe, acted on only when it coincides with `hd_i` |
| shutter_en_i | input | 1 | Electronic shutter enable |
| sg_hold_i | input | 1 | Readout-gate override (suppresses readout) |
| frame_mode_i | input | 1 | 1 selects the frame-mode readout midpoint, 0 the draft-mode midpoint |
| vcount_i | input | 10 | Vertical count (extra fields in the span) |
| hcount_i | input | 12 | Horizontal count; bit 11 is reserved |
| pfield_i | input | 10 | Partial-field index for the burst |
| sub_o | output | 1 | Substrate-discharge pulse |
| exp_o | output | 1 | Exposure flag |
| readout_o | output | 1 | One-cycle readout-midpoint strobe |
| busy_o | output | 1 | Multi-field span in progress |

## Verification
The bench sweeps high-speed and multi-field spans. These include a partial-field index larger than the vertical count, which a design without the clamp would answer with no burst at all and no rise of the exposure flag. It also sets the reserved MSB of the horizontal count, which a design decoding all twelve bits would answer with far too many discharge lines, and it rewrites the inputs in the middle of a span, which exposes a design that reloads parameters at every field strobe. Directed cases hold the readout override through a whole field, where a faulty design would clear the flag or emit a strobe. They also assert reset in the middle of a discharge pulse, where a faulty design would leave the pulse or the busy flag standing.

// File: rtl/ccdsh_pkg.sv
package ccdsh_pkg;

    // Width of the vertical count and partial-field index.
    localparam int SH_VW = 10;
    // Usable width of the horizontal count (the port carries one reserved MSB more).
    localparam int SH_HW = 11;

    typedef struct packed {
        logic             en;
        logic [SH_VW-1:0] v;
        logic [SH_HW-1:0] h;
        logic [SH_VW-1:0] p;
    } shut_par_t;

endpackage

// File: rtl/ccdsh_linetimer.sv
module ccdsh_linetimer #(
    parameter int CW = 12,
    parameter int LW = 11
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hd_i,
    input  logic          vd_i,
    output logic [CW-1:0] cnt_o,
    output logic [LW-1:0] line_o,
    output logic          live_o,
    output logic          fs_o
);

    localparam logic [CW-1:0] CNT_MAX  = '1;
    localparam logic [LW-1:0] LINE_MAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [LW-1:0] line;
        logic          live;
    } lt_t;

    lt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hd_i) begin
            st_d.cnt = '0;
            if (vd_i) begin
                st_d.line = '0;
                st_d.live = 1'b1;
            end else if (st_q.line != LINE_MAX) begin
                st_d.line = st_q.line + 1'b1;
            end
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign line_o = st_q.line;
    assign live_o = st_q.live;
    assign fs_o   = hd_i & vd_i;

endmodule

// File: rtl/ccdsh_fieldctl.sv
module ccdsh_fieldctl
    import ccdsh_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fs_i,
    input  logic             shutter_en_i,
    input  logic [SH_VW-1:0] vcount_i,
    input  logic [SH_HW-1:0] hcount_i,
    input  logic [SH_VW-1:0] pfield_i,
    output logic [SH_VW-1:0] k_o,
    output shut_par_t        par_o,
    output logic             busy_o
);

    typedef struct packed {
        logic [SH_VW-1:0] k;
        shut_par_t        par;
        logic             busy;
    } fc_t;

    fc_t  fc_d, fc_q;
    logic span_end;

    assign span_end = (fc_q.k == fc_q.par.v);

    always_comb begin
        fc_d = fc_q;
        if (fs_i) begin
            if (span_end) begin
                fc_d.k      = '0;
                fc_d.par.en = shutter_en_i;
                if (shutter_en_i) begin
                    fc_d.par.v = vcount_i;
                    fc_d.par.h = hcount_i;
                    fc_d.par.p = (pfield_i > vcount_i) ? vcount_i : pfield_i;
                end else begin
                    fc_d.par.v = '0;
                    fc_d.par.h = '0;
                    fc_d.par.p = '0;
                end
                fc_d.busy = shutter_en_i && (vcount_i != '0);
            end else begin
                fc_d.k = fc_q.k + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fc_q <= '0;
        end else begin
            fc_q <= fc_d;
        end
    end

    assign k_o    = fc_q.k;
    assign par_o  = fc_q.par;
    assign busy_o = fc_q.busy;

endmodule

// File: rtl/ccdsh_pulsegen.sv
module ccdsh_pulsegen
    import ccdsh_pkg::*;
#(
    parameter int CW         = 12,
    parameter int LW         = 11,
    parameter int SUB_ON     = 60,
    parameter int SUB_OFF    = 124,
    parameter int MID_FRAME  = 1260,
    parameter int MID_DRAFT  = 1338,
    parameter int NOSUB_RISE = 1416
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CW-1:0]    cnt_i,
    input  logic [LW-1:0]    line_i,
    input  logic             live_i,
    input  logic [SH_VW-1:0] k_i,
    input  shut_par_t        par_i,
    input  logic             sg_hold_i,
    input  logic             frame_mode_i,
    output logic             sub_o,
    output logic             readout_o,
    output logic             exp_o
);

    localparam int EW = ((LW > SH_HW) ? LW : SH_HW) + 1;

    typedef struct packed {
        logic sub;
        logic rd;
        logic expf;
    } pg_t;

    pg_t           pg_d, pg_q;
    logic [CW-1:0] mid;
    logic [EW-1:0] last_line;
    logic [EW-1:0] line_w;
    logic          rd_line, rd_fire, burst_field, in_burst;

    assign mid         = frame_mode_i ? CW'(MID_FRAME) : CW'(MID_DRAFT);
    assign line_w      = EW'(line_i);
    assign last_line   = EW'(par_i.h) + EW'(1);
    assign rd_line     = live_i && (line_i == '0) && (k_i == '0);
    assign rd_fire     = rd_line && !sg_hold_i && (cnt_i == mid);
    assign burst_field = live_i && par_i.en && (k_i == par_i.p);
    assign in_burst    = burst_field && (line_i != '0) && (line_w <= last_line);

    always_comb begin
        pg_d      = pg_q;
        pg_d.sub  = in_burst && (cnt_i >= CW'(SUB_ON)) && (cnt_i < CW'(SUB_OFF));
        pg_d.rd   = rd_fire;
        if (rd_fire) begin
            pg_d.expf = 1'b0;
        end else if (burst_field && (line_w == last_line) && (cnt_i == CW'(SUB_OFF))) begin
            pg_d.expf = 1'b1;
        end else if (rd_line && !sg_hold_i && !par_i.en && (cnt_i == CW'(NOSUB_RISE))) begin
            pg_d.expf = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pg_q <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign sub_o     = pg_q.sub;
    assign readout_o = pg_q.rd;
    assign exp_o     = pg_q.expf;

endmodule

// File: rtl/ccd_shutter_seq.sv
module ccd_shutter_seq
    import ccdsh_pkg::*;
#(
    parameter int CW         = 12,
    parameter int LW         = 11,
    parameter int SUB_ON     = 60,
    parameter int SUB_OFF    = 124,
    parameter int MID_FRAME  = 1260,
    parameter int MID_DRAFT  = 1338,
    parameter int NOSUB_RISE = 1416
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hd_i,
    input  logic             vd_i,
    input  logic             shutter_en_i,
    input  logic             sg_hold_i,
    input  logic             frame_mode_i,
    input  logic [SH_VW-1:0] vcount_i,
    input  logic [SH_HW:0]   hcount_i,
    input  logic [SH_VW-1:0] pfield_i,
    output logic             sub_o,
    output logic             exp_o,
    output logic             readout_o,
    output logic             busy_o
);

    logic [CW-1:0]    cnt;
    logic [LW-1:0]    line;
    logic             live;
    logic             fs;
    logic [SH_VW-1:0] k;
    shut_par_t        par;

    ccdsh_linetimer #(
        .CW (CW),
        .LW (LW)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hd_i   (hd_i),
        .vd_i   (vd_i),
        .cnt_o  (cnt),
        .line_o (line),
        .live_o (live),
        .fs_o   (fs)
    );

    // Bit SH_HW of the horizontal count is reserved and is not passed on.
    ccdsh_fieldctl u_field (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fs_i         (fs),
        .shutter_en_i (shutter_en_i),
        .vcount_i     (vcount_i),
        .hcount_i     (hcount_i[SH_HW-1:0]),
        .pfield_i     (pfield_i),
        .k_o          (k),
        .par_o        (par),
        .busy_o       (busy_o)
    );

    ccdsh_pulsegen #(
        .CW         (CW),
        .LW         (LW),
        .SUB_ON     (SUB_ON),
        .SUB_OFF    (SUB_OFF),
        .MID_FRAME  (MID_FRAME),
        .MID_DRAFT  (MID_DRAFT),
        .NOSUB_RISE (NOSUB_RISE)
    ) u_pulse (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cnt_i        (cnt),
        .line_i       (line),
        .live_i       (live),
        .k_i          (k),
        .par_i        (par),
        .sg_hold_i    (sg_hold_i),
        .frame_mode_i (frame_mode_i),
        .sub_o        (sub_o),
        .readout_o    (readout_o),
        .exp_o        (exp_o)
    );

endmodule

// File: rtl/ccdsh_checker.sv
module ccdsh_checker #(
    parameter int SUB_ON  = 60,
    parameter int SUB_OFF = 124
) (
    input logic clk_i,
    input logic rst_ni,
    input logic hd_i,
    input logic vd_i,
    input logic sg_hold_i,
    input logic sub_o,
    input logic exp_o,
    input logic readout_o,
    input logic busy_o
);

    logic [15:0] run_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else begin
            run_q <= sub_o ? run_q + 16'd1 : 16'd0;
        end
    end

    assert_sub_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sub_o) |-> (run_q == 16'(SUB_OFF - SUB_ON)));

    assert_readout_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        readout_o |=> !readout_o);

    assert_exp_fall_at_readout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(exp_o) |-> readout_o);

    assert_hold_blocks_readout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        readout_o |-> !$past(sg_hold_i));

    assert_busy_at_field_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(busy_o) |-> $past(hd_i && vd_i));

endmodule

bind ccd_shutter_seq ccdsh_checker #(
    .SUB_ON  (SUB_ON),
    .SUB_OFF (SUB_OFF)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hd_i      (hd_i),
    .vd_i      (vd_i),
    .sg_hold_i (sg_hold_i),
    .sub_o     (sub_o),
    .exp_o     (exp_o),
    .readout_o (readout_o),
    .busy_o    (busy_o)
);

// File: tb/ccd_shutter_seq_tb.sv
module ccd_shutter_seq_tb;

    localparam int ON   = 6;
    localparam int OFF  = 12;
    localparam int MF   = 30;
    localparam int MD   = 38;
    localparam int NSR  = 46;
    localparam int NL   = 8;
    localparam int LL   = 60;
    localparam int NROW = 7;

    typedef struct packed {
        logic        en;
        logic [9:0]  v;
        logic [11:0] h;
        logic [9:0]  p;
        logic        fr;
        logic [3:0]  subs;
        logic [3:0]  rf;
        logic [3:0]  rl;
        logic        bsy;
    } row_t;

    // en, v, h, p, frame | expected pulses, rise field, rise line, busy
    localparam row_t ROWS [NROW] = '{
        '{1'b0, 10'd3, 12'd2,     10'd1, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0},
        '{1'b1, 10'd0, 12'd2,     10'd0, 1'b1, 4'd3, 4'd0, 4'd3, 1'b0},
        '{1'b1, 10'd0, 12'd0,     10'd0, 1'b0, 4'd1, 4'd0, 4'd1, 1'b0},
        '{1'b1, 10'd2, 12'd4,     10'd1, 1'b0, 4'd5, 4'd1, 4'd5, 1'b1},
        '{1'b1, 10'd1, 12'd6,     10'd5, 1'b1, 4'd7, 4'd1, 4'd7, 1'b1},
        '{1'b1, 10'd2, 12'd3,     10'd0, 1'b1, 4'd4, 4'd0, 4'd4, 1'b1},
        '{1'b1, 10'd0, 12'h805,   10'd0, 1'b0, 4'd6, 4'd0, 4'd6, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hd, vd, en, hold, frm;
    logic [9:0]  vcnt, pfld;
    logic [11:0] hcnt;
    logic        sub, expf, rdo, busy;

    int total = 0;
    int bad   = 0;

    int n_sub, sub_bad, n_rd, rd_bad, busy_bad, exp_lo;
    int rise_seen, rise_f, rise_l, rise_c;
    int pe, hl, mid, exp_busy;
    logic prev_sub = 1'b0;
    logic prev_exp = 1'b0;

    always #2 clk = ~clk;

    ccd_shutter_seq #(
        .CW (8), .LW (5), .SUB_ON (ON), .SUB_OFF (OFF),
        .MID_FRAME (MF), .MID_DRAFT (MD), .NOSUB_RISE (NSR)
    ) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .hd_i (hd), .vd_i (vd),
        .shutter_en_i (en), .sg_hold_i (hold), .frame_mode_i (frm),
        .vcount_i (vcnt), .hcount_i (hcnt), .pfield_i (pfld),
        .sub_o (sub), .exp_o (expf), .readout_o (rdo), .busy_o (busy)
    );

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Drive strobes at the falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic h, input logic v);
        hd = h;
        vd = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_mon();
        n_sub = 0; sub_bad = 0; n_rd = 0; rd_bad = 0; busy_bad = 0; exp_lo = 0;
        rise_seen = 0; rise_f = -1; rise_l = -1; rise_c = -1;
    endtask

    task automatic observe(input int f, input int l, input int c);
        if (sub && !prev_sub) n_sub++;
        if (sub && (c < ON + 1 || c > OFF || f != pe || l < 1 || l > hl)) sub_bad++;
        if (rdo) begin
            n_rd++;
            if (!(f == 0 && l == 0 && c == mid + 1)) rd_bad++;
            if (expf) rd_bad++;
        end
        if (expf && !prev_exp && rise_seen == 0) begin
            rise_seen = 1; rise_f = f; rise_l = l; rise_c = c;
        end
        if (!expf) exp_lo++;
        if (l == 0 && c == 1 && busy !== exp_busy[0]) busy_bad++;
        prev_sub = sub;
        prev_exp = expf;
    endtask

    task automatic run_field(input int f);
        for (int l = 0; l < NL; l++) begin
            for (int c = 0; c < LL; c++) begin
                step(c == 0, (c == 0) && (l == 0));
                observe(f, l, c);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hd = 1'b0; vd = 1'b0; en = 1'b0; hold = 1'b0; frm = 1'b0;
        vcnt = '0; hcnt = '0; pfld = '0;
        @(negedge clk);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 reset sub",     int'(sub),  0);
        chk("R1 reset exp",     int'(expf), 0);
        chk("R1 reset readout", int'(rdo),  0);
        chk("R1 reset busy",    int'(busy), 0);
        rst_n = 1'b1;

        // Line strobes without a field strobe: nothing may happen.
        en = 1'b1; hcnt = 12'd3;
        clear_mon();
        for (int l = 0; l < 2; l++) begin
            for (int c = 0; c < LL; c++) begin
                step(c == 0, 1'b0);
                if (sub || rdo || expf) n_rd++;
            end
        end
        chk("R1 idle before first field", n_rd, 0);

        // Table walk: one full span per row; inputs are scrambled after field 0.
        for (int i = 0; i < NROW; i++) begin
            en = ROWS[i].en; vcnt = ROWS[i].v; hcnt = ROWS[i].h;
            pfld = ROWS[i].p; frm = ROWS[i].fr;
            pe  = ROWS[i].en ? ((ROWS[i].p > ROWS[i].v) ? int'(ROWS[i].v) : int'(ROWS[i].p)) : -1;
            hl  = int'(ROWS[i].h[10:0]) + 1;
            mid = ROWS[i].fr ? MF : MD;
            exp_busy = int'(ROWS[i].bsy);
            clear_mon();
            for (int f = 0; f < (ROWS[i].en ? int'(ROWS[i].v) + 1 : 1); f++) begin
                if (f == 1) begin
                    en = ~en; vcnt = '0; hcnt = '0; pfld = '0; frm = ~frm;
                end
                run_field(f);
            end
            chk($sformatf("R3 row%0d pulse count", i), n_sub, int'(ROWS[i].subs));
            chk($sformatf("R2 row%0d pulse window/line/field", i), sub_bad, 0);
            chk($sformatf("R5 row%0d readouts per span", i), n_rd, 1);
            chk($sformatf("R8 row%0d readout position and exp low", i), rd_bad, 0);
            chk($sformatf("R6 row%0d exp rise field", i), rise_f, int'(ROWS[i].rf));
            chk($sformatf("%s row%0d exp rise line", ROWS[i].en ? "R7" : "R4", i),
                rise_l, int'(ROWS[i].rl));
            chk($sformatf("%s row%0d exp rise clock", ROWS[i].en ? "R7" : "R4", i),
                rise_c, ROWS[i].en ? OFF + 1 : NSR + 1);
            chk($sformatf("R10 row%0d busy during span", i), busy_bad, 0);
        end

        // Readout override across a whole field: exposure must carry on.
        en = 1'b0; hold = 1'b1; frm = 1'b0; mid = MD; pe = -1; hl = 0; exp_busy = 0;
        clear_mon();
        run_field(0);
        chk("R9 readout suppressed", n_rd, 0);
        chk("R9 exp held high", exp_lo, 0);
        hold = 1'b0;
        clear_mon();
        run_field(0);
        chk("R9 readout resumes", n_rd, 1);
        chk("R4 no-shutter exp rise clock", rise_c, NSR + 1);
        chk("R4 no pulses with shutter off", n_sub, 0);

        // Reset in the middle of a discharge pulse.
        en = 1'b1; vcnt = 10'd2; hcnt = 12'd6; pfld = 10'd0;
        for (int l = 0; l < 3; l++) begin
            for (int c = 0; c < LL; c++) step(c == 0, (c == 0) && (l == 0));
        end
        for (int c = 0; c <= ON + 2; c++) step(c == 0, 1'b0);
        chk("R2 pulse high before reset", int'(sub), 1);
        chk("R10 busy before reset", int'(busy), 1);
        rst_n = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 mid-pulse reset sub", int'(sub), 0);
        chk("R1 mid-pulse reset busy", int'(busy), 0);
        chk("R1 mid-pulse reset exp", int'(expf), 0);
        rst_n = 1'b1;
        n_rd = 0;
        for (int c = 0; c < LL; c++) begin
            step(c == 0, 1'b0);
            if (sub || rdo) n_rd++;
        end
        chk("R1 no activity after reset", n_rd, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule